// File: doc/BRIEF.md
# Seconds Time Base with Alarm

This block keeps wall-clock time for a low-power domain. It runs directly on the 32.768 kHz clock. One 47-bit register advances by one on every clock edge. Its upper 32 bits count whole seconds and its lower 15 bits count the fraction of the current second. Software sets the time, arms an alarm, and reads the time back through a word-wide register port. Writes take effect on the clock edge. Reads are combinational on the address.

The counter starts only when three conditions hold. Software must have set the enable bit. It must have written the seconds word at least once since reset. It must have cleared the not-valid flag, which comes up set after reset. The alarm compares the full counter against an alarm seconds word and an alarm fraction word. On a match it sets a sticky flag, and software clears that flag by writing 1 to it. The interrupt line is the alarm flag gated by its enable bit. A security-violation flag is set from an input pulse and is cleared in the same write-1 style. There is no periodic interrupt.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, the status word reads 0x2 (not-valid set, alarm and violation flags clear). The counter words and the control word read 0. The alarm seconds word reads 0xFFFFFFFF and the alarm fraction reads 0.
- R2: The 47-bit counter advances by exactly one per clock only while three things are true: control bit 3 (offset 0x10) is 1, the seconds word has been written since reset, and the not-valid flag is 0. Otherwise it holds.
- R3: A write to offset 0x00 loads counter bits 46:15 and marks the seconds word as written. A write to offset 0x04 loads counter bits 14:0 from data bits 14:0. In a cycle with either write, the counter does not increment.
- R4: When the counter holds all ones and advances, it wraps to zero.
- R5: The alarm seconds word is at 0x08 and the alarm fraction word is at 0x0C (15 bits). The alarm flag (status bit 4) becomes 1 on the clock edge after a cycle in which the counter equals {alarm seconds, alarm fraction}.
- R6: The status word at 0x14 has these fields: bit 4 is the alarm flag, bit 1 is not-valid, bit 0 is security-violation. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R7: If a flag's set condition and its write-1 clear fall in the same cycle, the set wins and the flag stays 1.
- R8: A high level on `sec_viol` at a clock edge sets the security-violation flag.
- R9: `irq` is 1 exactly when the alarm flag is 1 and bit 4 of the enable word at 0x18 is 1.
- R10: Bits that are not defined read as 0. Unmapped offsets read 0. Only bit 3 of the control word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sec_viol | input | 1 | Security-violation set pulse |
| irq | output | 1 | Alarm interrupt |

## Verification
Two events can fall in the same cycle. One is an alarm match, which sets the alarm flag. The other is a write-1 clear of that flag. The bench provokes this collision by stopping the counter at a value equal to the alarm, so the match is present in every cycle, and then issuing the clear. It judges the result by reading status bit 4 and `irq`, both of which must stay 1. The same collision is staged for the violation flag by pulsing `sec_viol` in the cycle of its clear. A behavioural model, updated on every edge, supplies the expected read data and interrupt level for every other cycle.

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int AW     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [SEC_W-1:0] reg_wdata,
  output logic [SEC_W-1:0] reg_rdata,
  input  logic             sec_viol,
  output logic             irq
);
  localparam int CNT_W = SEC_W + FRAC_W;
  localparam logic [AW-1:0] A_SEC  = AW'(5'h00);
  localparam logic [AW-1:0] A_FRAC = AW'(5'h04);
  localparam logic [AW-1:0] A_ASEC = AW'(5'h08);
  localparam logic [AW-1:0] A_AFRC = AW'(5'h0C);
  localparam logic [AW-1:0] A_CTRL = AW'(5'h10);
  localparam logic [AW-1:0] A_STAT = AW'(5'h14);
  localparam logic [AW-1:0] A_IEN  = AW'(5'h18);
  localparam int B_EN  = 3;
  localparam int B_ALM = 4;
  localparam int B_NV  = 1;
  localparam int B_SV  = 0;

  logic [CNT_W-1:0]  cnt;
  logic [SEC_W-1:0]  alm_sec;
  logic [FRAC_W-1:0] alm_frac;
  logic en, written, alm_flag, nv, sv, ie;

  wire wr_sec  = reg_we && reg_addr == A_SEC;
  wire wr_frac = reg_we && reg_addr == A_FRAC;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire cnt_we  = wr_sec || wr_frac;
  wire run     = en && written && !nv;
  wire match   = cnt == {alm_sec, alm_frac};
  wire clr_alm = wr_stat && reg_wdata[B_ALM];
  wire clr_nv  = wr_stat && reg_wdata[B_NV];
  wire clr_sv  = wr_stat && reg_wdata[B_SV];

  assign irq = alm_flag && ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      written <= 1'b0;
    end else if (wr_sec) begin
      cnt[CNT_W-1:FRAC_W] <= reg_wdata;
      written             <= 1'b1;
    end else if (wr_frac)
      cnt[FRAC_W-1:0] <= reg_wdata[FRAC_W-1:0];
    else if (run)
      cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alm_sec  <= '1;
      alm_frac <= '0;
      en       <= 1'b0;
      ie       <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_ASEC) alm_sec  <= reg_wdata;
      if (reg_addr == A_AFRC) alm_frac <= reg_wdata[FRAC_W-1:0];
      if (reg_addr == A_CTRL) en       <= reg_wdata[B_EN];
      if (reg_addr == A_IEN)  ie       <= reg_wdata[B_ALM];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alm_flag <= 1'b0;
      nv       <= 1'b1;
      sv       <= 1'b0;
    end else begin
      alm_flag <= (alm_flag && !clr_alm) || match;
      nv       <= nv && !clr_nv;
      sv       <= (sv && !clr_sv) || sec_viol;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SEC:  reg_rdata = cnt[CNT_W-1:FRAC_W];
      A_FRAC: reg_rdata[FRAC_W-1:0] = cnt[FRAC_W-1:0];
      A_ASEC: reg_rdata = alm_sec;
      A_AFRC: reg_rdata[FRAC_W-1:0] = alm_frac;
      A_CTRL: reg_rdata[B_EN] = en;
      A_STAT: begin
        reg_rdata[B_ALM] = alm_flag;
        reg_rdata[B_NV]  = nv;
        reg_rdata[B_SV]  = sv;
      end
      A_IEN:  reg_rdata[B_ALM] = ie;
      default: reg_rdata = '0;
    endcase
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_we) |=> cnt == $past(cnt) + 1'b1);
  a_r3_marker: assert property (@(posedge clk) disable iff (!rst_n)
    written |=> written);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> alm_flag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !clr_alm) |=> alm_flag);
  a_r8_viol: assert property (@(posedge clk) disable iff (!rst_n)
    sec_viol |=> sv);
endmodule

// File: tb/tb_rtc_timebase.sv
module tb_rtc_timebase;
  logic clk = 0, rst_n = 0, reg_we = 0, sec_viol = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_timebase dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_viol(sec_viol), .irq(irq));

  localparam longint MASK = 64'h7FFF_FFFF_FFFF;
  longint m_cnt, m_asec, m_afrac;
  bit m_en, m_wr, m_flag, m_nv, m_sv, m_ie;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_asec = 64'hFFFF_FFFF; m_afrac = 0;
      m_en = 0; m_wr = 0; m_flag = 0; m_nv = 1; m_sv = 0; m_ie = 0;
    end else begin
      bit hit, go, st;
      hit = (m_cnt >> 15) == m_asec && (m_cnt & 64'h7FFF) == m_afrac;
      go  = m_en && m_wr && !m_nv;
      st  = reg_we && reg_addr == 5'h14;
      if (reg_we && reg_addr == 5'h00) begin
        m_cnt = (longint'(reg_wdata) << 15) | (m_cnt & 64'h7FFF); m_wr = 1;
      end else if (reg_we && reg_addr == 5'h04)
        m_cnt = (m_cnt & ~64'h7FFF) | longint'(reg_wdata & 32'h7FFF);
      else if (go) m_cnt = (m_cnt + 1) & MASK;
      if (reg_we && reg_addr == 5'h08) m_asec = longint'(reg_wdata);
      if (reg_we && reg_addr == 5'h0C) m_afrac = longint'(reg_wdata & 32'h7FFF);
      if (reg_we && reg_addr == 5'h10) m_en = reg_wdata[3];
      if (reg_we && reg_addr == 5'h18) m_ie = reg_wdata[4];
      m_flag = (m_flag && !(st && reg_wdata[4])) || hit;
      m_nv   = m_nv && !(st && reg_wdata[1]);
      m_sv   = (m_sv && !(st && reg_wdata[0])) || sec_viol;
    end
  end

  function automatic longint exp_rd(logic [4:0] a);
    case (a)
      5'h00: return (m_cnt >> 15) & 64'hFFFF_FFFF;
      5'h04: return m_cnt & 64'h7FFF;
      5'h08: return m_asec;
      5'h0C: return m_afrac;
      5'h10: return m_en ? 8 : 0;
      5'h14: return (longint'(m_flag) << 4) | (longint'(m_nv) << 1) | longint'(m_sv);
      5'h18: return m_ie ? 16 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (addr 0x%0h)", tag, got, exp, reg_addr);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    string tag;
    case (reg_addr)
      5'h00, 5'h04: tag = "R2 counter";
      5'h08, 5'h0C: tag = "R5 alarm";
      5'h14: tag = "R6 status";
      5'h18: tag = "R9 enable";
      default: tag = "R10 map";
    endcase
    chk(tag, longint'(reg_rdata), exp_rd(reg_addr));
    chk("R9 irq", longint'(irq), longint'(m_flag && m_ie));
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask
  task automatic peek(logic [4:0] a, string tag, longint exp);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk); chk(tag, longint'(reg_rdata), exp);
  endtask
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint a, b;
    idle(3); #1 rst_n = 1;
    peek(5'h14, "R1 status", 2);
    peek(5'h00, "R1 seconds", 0);
    peek(5'h10, "R1 control", 0);
    peek(5'h08, "R1 alarm sec", 64'hFFFF_FFFF);
    wr(5'h10, 8); idle(5);
    peek(5'h04, "R2 frozen before seconds write", 0);
    wr(5'h00, 5); idle(5);
    peek(5'h04, "R2 frozen while not-valid", 0);
    peek(5'h00, "R3 seconds load", 5);
    wr(5'h14, 2); idle(3);
    @(posedge clk); #1 reg_addr = 5'h04;
    @(negedge clk); a = longint'(reg_rdata);
    @(negedge clk); b = longint'(reg_rdata);
    chk("R2 step of one", b, a + 1);
    peek(5'h1C, "R10 unmapped", 0);
    wr(5'h10, 32'hFFFF_FFFF);
    peek(5'h10, "R10 control bits", 8);
    wr(5'h10, 0);
    wr(5'h04, 32'hFFFF_1234);
    peek(5'h04, "R3 fraction load", 32'h1234);
    peek(5'h00, "R3 seconds kept", 5);
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'h7FFD); wr(5'h10, 8); idle(6);
    peek(5'h00, "R4 wrap", 0);
    wr(5'h10, 0); wr(5'h00, 10); wr(5'h04, 0);
    wr(5'h08, 10); wr(5'h0C, 20); wr(5'h18, 16); wr(5'h10, 8); idle(30);
    peek(5'h14, "R5 alarm flag", 16);
    chk("R9 irq asserted", longint'(irq), 1);
    wr(5'h14, 16);
    peek(5'h14, "R6 alarm cleared", 0);
    chk("R9 irq released", longint'(irq), 0);
    wr(5'h10, 0); wr(5'h00, 100); wr(5'h04, 50);
    wr(5'h08, 100); wr(5'h0C, 50); idle(2);
    wr(5'h14, 16);
    peek(5'h14, "R7 set beats clear", 16);
    wr(5'h18, 0);
    peek(5'h14, "R9 flag kept", 16);
    chk("R9 masked", longint'(irq), 0);
    wr(5'h08, 200); wr(5'h14, 0);
    peek(5'h14, "R6 write zero no effect", 16);
    wr(5'h14, 16);
    peek(5'h14, "R6 clear", 0);
    @(posedge clk); #1 sec_viol = 1; @(posedge clk); #1 sec_viol = 0;
    peek(5'h14, "R8 violation set", 1);
    @(posedge clk); #1 sec_viol = 1; reg_we = 1; reg_addr = 5'h14; reg_wdata = 1;
    @(posedge clk); #1 sec_viol = 0; reg_we = 0;
    peek(5'h14, "R7 violation set beats clear", 1);
    wr(5'h14, 1);
    peek(5'h14, "R6 violation cleared", 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule